// File: doc/BRIEF.md
# Single-Bit Alias Address Translator

This block sits between one bus master and the memory bus. It gives software atomic access to single bits of memory and peripheral words through two alias windows. Each window holds one 32-bit word per bit of a 1 MB backing region, so it spans 32 MB. A word access that lands in a window is turned into an access to one bit of the backing word.

A read through a window returns that bit. A write through a window becomes a locked read-modify-write that changes only that bit. Any address outside both windows passes to the memory bus unchanged, as a single transaction.

Both sides use a simple valid/ready request handshake. Each transaction is answered by a single-cycle response pulse. The downstream side also carries a lock signal. The lock stays asserted from the read of an alias write until the response to its write-back, so that no other master can slip in between.

Top module: `bitband_xlate`

## Requirements
- R1: A request whose address lies outside both alias windows makes exactly one downstream transaction, with the same address, direction and write data, and with the lock low. A read returns the downstream read data, and a write returns 0.
- R2: Window 0 covers 0x22000000 to 0x23FFFFFC and maps onto the region at 0x20000000. For alias offset `o`, the byte is `o/32` and the bit within that byte is `(o%32)/4`. The backing word address is the region base plus the byte with its low 2 bits cleared, and the bit index in that word is `(byte%4)*8` plus the bit within the byte.
- R3: Window 1 covers 0x42000000 to 0x43FFFFFC and maps onto the region at 0x40000000, using the same arithmetic as R2.
- R4: An alias read makes one unlocked downstream read of the backing word. It returns the selected bit in bit 0 of the response, with all other bits zero.
- R5: An alias write makes exactly two downstream transactions to the backing word: a read, then a write. The word written back equals the word read, with the selected bit replaced by bit 0 of the request write data. The other 31 bits of the request write data have no effect.
- R6: During an alias write, the lock is high on both downstream transactions and stays high without a gap from the read request until the write-back response. Pass-through accesses and alias reads never raise the lock.
- R7: Only one request is in flight at a time. The upstream ready is low from acceptance until the response. The upstream response is a one-cycle pulse, and a downstream request holds its address, direction, data and lock steady until it is accepted.
- R8: If the word at 0x20000000 is cleared and 1 is then written to alias address 0x22000008, a later read of 0x20000000 returns 4.
- R9: The last word of each window (0x23FFFFFC, 0x43FFFFFC) maps to bit 31 of the last word of its region. The words just outside each window (0x21FFFFFC, 0x24000000, 0x41FFFFFC, 0x44000000) pass through unchanged.
- R10: While reset is applied and just after it, upstream ready is high and downstream valid, lock and upstream response valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Block can take a request |
| up_write | input | 1 | Request is a write |
| up_addr | input | 32 | Request byte address |
| up_wdata | input | 32 | Request write data |
| up_rsp_valid | output | 1 | One-cycle response pulse |
| up_rdata | output | 32 | Response data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_write | output | 1 | Downstream request is a write |
| dn_lock | output | 1 | Bus lock for the read-modify-write |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response pulse |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The stimulus mixes pass-through reads and writes with alias reads and writes in both windows. All of these hit a small shared pool of backing words, so an alias write is later seen through both a pass-through read and an alias read. Alias write data carries random upper bits, which would expose a merge that takes more than bit 0. Pass-through addresses alongside the windows, together with the first and last alias words, separate an off-by-one window decode from a correct one. Random downstream ready stalls and response latency show whether the lock has a gap or whether a request changes before it is accepted.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_WR_REQ,
      ST_WR_WAIT,
      ST_RESP
   } bb_state_e;

   typedef enum logic [1:0] {
      OP_PASS,
      OP_BIT_RD,
      OP_BIT_WR
   } bb_op_e;

endpackage

// File: rtl/bitband_region.sv
module bitband_region #(
   parameter int unsigned            ADDR_W   = 32,
   parameter int unsigned            WIN_BITS = 20,
   parameter int unsigned            BIT_W    = 5,
   parameter int unsigned            LANE_W   = 2,
   parameter logic [ADDR_W-1:0]      BASE     = 32'h2000_0000,
   parameter logic [ADDR_W-1:0]      ALIAS    = 32'h2200_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] word_addr,
   output logic [BIT_W-1:0]  bit_idx
);
   localparam int unsigned ALIAS_BITS = WIN_BITS + BIT_W;

   if (BASE[WIN_BITS-1:0] != '0) begin : g_bad_base
      $error("bitband_region: region base not aligned to its size");
   end
   if (ALIAS[ALIAS_BITS-1:0] != '0) begin : g_bad_alias
      $error("bitband_region: alias base not aligned to its window");
   end

   logic [ALIAS_BITS-1:0] offs;
   logic [ADDR_W-1:0]     word_off;
   logic [LANE_W-1:0]     unused_low;

   assign offs       = addr[ALIAS_BITS-1:0];
   assign unused_low = offs[LANE_W-1:0];
   assign hit        = (addr[ADDR_W-1:ALIAS_BITS] == ALIAS[ADDR_W-1:ALIAS_BITS]);

   always_comb begin
      word_off = '0;
      word_off[WIN_BITS-1:0] = {offs[ALIAS_BITS-1:BIT_W+LANE_W], {LANE_W{1'b0}}};
   end

   assign word_addr = BASE + word_off;
   assign bit_idx   = offs[BIT_W+LANE_W-1:LANE_W];

endmodule

// File: rtl/bitband_decode.sv
module bitband_decode #(
   parameter int unsigned                ADDR_W    = 32,
   parameter int unsigned                WIN_BITS  = 20,
   parameter int unsigned                BIT_W     = 5,
   parameter int unsigned                LANE_W    = 2,
   parameter int unsigned                NREG      = 2,
   parameter logic [NREG*ADDR_W-1:0]     BASE_VEC  = {32'h4000_0000, 32'h2000_0000},
   parameter logic [NREG*ADDR_W-1:0]     ALIAS_VEC = {32'h4200_0000, 32'h2200_0000}
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_alias,
   output logic [ADDR_W-1:0] target_addr,
   output logic [BIT_W-1:0]  bit_idx
);
   logic [NREG-1:0]   hit;
   logic [ADDR_W-1:0] wa [NREG];
   logic [BIT_W-1:0]  bi [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_rgn
      bitband_region #(
         .ADDR_W   (ADDR_W),
         .WIN_BITS (WIN_BITS),
         .BIT_W    (BIT_W),
         .LANE_W   (LANE_W),
         .BASE     (BASE_VEC[g*ADDR_W +: ADDR_W]),
         .ALIAS    (ALIAS_VEC[g*ADDR_W +: ADDR_W])
      ) u_rgn (
         .addr      (addr),
         .hit       (hit[g]),
         .word_addr (wa[g]),
         .bit_idx   (bi[g])
      );
   end

   always_comb begin
      is_alias    = 1'b0;
      target_addr = addr;
      bit_idx     = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) begin
            is_alias    = 1'b1;
            target_addr = wa[i];
            bit_idx     = bi[i];
         end
      end
   end

endmodule

// File: rtl/bitband_bitops.sv
module bitband_bitops #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BIT_W  = 5
) (
   input  logic [DATA_W-1:0] word,
   input  logic [BIT_W-1:0]  bit_idx,
   input  logic              new_val,
   output logic [DATA_W-1:0] rd_bit,
   output logic [DATA_W-1:0] merged
);
   for (genvar j = 0; j < DATA_W; j++) begin : g_lane
      assign merged[j] = (bit_idx == BIT_W'(j)) ? new_val : word[j];
   end

   always_comb begin
      rd_bit    = '0;
      rd_bit[0] = word[bit_idx];
   end

endmodule

// File: rtl/bitband_seq.sv
module bitband_seq
   import bitband_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BIT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic              up_write,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_rsp_valid,
   output logic [DATA_W-1:0] up_rdata,
   input  logic              dec_alias,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic [BIT_W-1:0]  dec_bit,
   output logic [BIT_W-1:0]  bit_q,
   output logic              new_val,
   input  logic [DATA_W-1:0] rd_bit,
   input  logic [DATA_W-1:0] merged,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic              dn_write,
   output logic              dn_lock,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rsp_valid,
   input  logic [DATA_W-1:0] dn_rdata
);
   bb_state_e         state_q;
   bb_op_e            op_q;
   logic              write_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] merged_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_PASS;
         write_q  <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         bit_q    <= '0;
         merged_q <= '0;
         rdata_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (up_valid) begin
               op_q    <= dec_alias ? (up_write ? OP_BIT_WR : OP_BIT_RD) : OP_PASS;
               write_q <= up_write;
               addr_q  <= dec_addr;
               wdata_q <= up_wdata;
               bit_q   <= dec_bit;
               state_q <= ST_RD_REQ;
            end
            ST_RD_REQ: if (dn_ready) state_q <= ST_RD_WAIT;
            ST_RD_WAIT: if (dn_rsp_valid) begin
               case (op_q)
                  OP_BIT_RD: begin
                     rdata_q <= rd_bit;
                     state_q <= ST_RESP;
                  end
                  OP_BIT_WR: begin
                     merged_q <= merged;
                     state_q  <= ST_WR_REQ;
                  end
                  default: begin
                     rdata_q <= write_q ? '0 : dn_rdata;
                     state_q <= ST_RESP;
                  end
               endcase
            end
            ST_WR_REQ: if (dn_ready) state_q <= ST_WR_WAIT;
            ST_WR_WAIT: if (dn_rsp_valid) begin
               rdata_q <= '0;
               state_q <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign new_val      = wdata_q[0];
   assign up_ready     = (state_q == ST_IDLE);
   assign up_rsp_valid = (state_q == ST_RESP);
   assign up_rdata     = rdata_q;
   assign dn_valid     = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
   assign dn_addr      = addr_q;
   assign dn_write     = (state_q == ST_WR_REQ) ||
                         ((state_q == ST_RD_REQ) && (op_q == OP_PASS) && write_q);
   assign dn_wdata     = (state_q == ST_WR_REQ) ? merged_q : wdata_q;
   assign dn_lock      = (op_q == OP_BIT_WR) && (state_q != ST_IDLE) && (state_q != ST_RESP);

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       WIN_BITS   = 20,
   parameter logic [ADDR_W-1:0] RGN0_BASE  = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] RGN0_ALIAS = 32'h2200_0000,
   parameter logic [ADDR_W-1:0] RGN1_BASE  = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] RGN1_ALIAS = 32'h4200_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic              up_write,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_rsp_valid,
   output logic [DATA_W-1:0] up_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic              dn_write,
   output logic              dn_lock,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rsp_valid,
   input  logic [DATA_W-1:0] dn_rdata
);
   localparam int unsigned BIT_W  = $clog2(DATA_W);
   localparam int unsigned LANE_W = $clog2(DATA_W / 8);
   localparam int unsigned NREG   = 2;
   localparam logic [NREG*ADDR_W-1:0] BASE_VEC  = {RGN1_BASE, RGN0_BASE};
   localparam logic [NREG*ADDR_W-1:0] ALIAS_VEC = {RGN1_ALIAS, RGN0_ALIAS};

   if (DATA_W < 8 || (1 << BIT_W) != DATA_W) begin : g_bad_data
      $error("bitband_xlate: DATA_W must be a power of two of at least 8");
   end
   if (ADDR_W <= WIN_BITS + BIT_W) begin : g_bad_addr
      $error("bitband_xlate: ADDR_W too small for the alias window");
   end

   logic              dec_alias;
   logic [ADDR_W-1:0] dec_addr;
   logic [BIT_W-1:0]  dec_bit;
   logic [BIT_W-1:0]  bit_q;
   logic              new_val;
   logic [DATA_W-1:0] rd_bit;
   logic [DATA_W-1:0] merged;

   bitband_decode #(
      .ADDR_W    (ADDR_W),
      .WIN_BITS  (WIN_BITS),
      .BIT_W     (BIT_W),
      .LANE_W    (LANE_W),
      .NREG      (NREG),
      .BASE_VEC  (BASE_VEC),
      .ALIAS_VEC (ALIAS_VEC)
   ) u_decode (
      .addr        (up_addr),
      .is_alias    (dec_alias),
      .target_addr (dec_addr),
      .bit_idx     (dec_bit)
   );

   bitband_bitops #(
      .DATA_W (DATA_W),
      .BIT_W  (BIT_W)
   ) u_bitops (
      .word    (dn_rdata),
      .bit_idx (bit_q),
      .new_val (new_val),
      .rd_bit  (rd_bit),
      .merged  (merged)
   );

   bitband_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BIT_W  (BIT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .up_valid     (up_valid),
      .up_ready     (up_ready),
      .up_write     (up_write),
      .up_wdata     (up_wdata),
      .up_rsp_valid (up_rsp_valid),
      .up_rdata     (up_rdata),
      .dec_alias    (dec_alias),
      .dec_addr     (dec_addr),
      .dec_bit      (dec_bit),
      .bit_q        (bit_q),
      .new_val      (new_val),
      .rd_bit       (rd_bit),
      .merged       (merged),
      .dn_valid     (dn_valid),
      .dn_ready     (dn_ready),
      .dn_write     (dn_write),
      .dn_lock      (dn_lock),
      .dn_addr      (dn_addr),
      .dn_wdata     (dn_wdata),
      .dn_rsp_valid (dn_rsp_valid),
      .dn_rdata     (dn_rdata)
   );

endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       WIN_BITS   = 20,
   parameter logic [ADDR_W-1:0] RGN0_ALIAS = 32'h2200_0000,
   parameter logic [ADDR_W-1:0] RGN1_ALIAS = 32'h4200_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_ready,
   input logic              up_rsp_valid,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic              dn_write,
   input logic              dn_lock,
   input logic [ADDR_W-1:0] dn_addr,
   input logic [DATA_W-1:0] dn_wdata,
   input logic              dn_rsp_valid,
   input logic [DATA_W-1:0] dn_rdata
);
   localparam int unsigned ALIAS_BITS = WIN_BITS + $clog2(DATA_W);

   logic              last_wr;
   logic              seen_ok;
   logic [DATA_W-1:0] seen_word;
   logic              in_win;

   assign in_win = (dn_addr[ADDR_W-1:ALIAS_BITS] == RGN0_ALIAS[ADDR_W-1:ALIAS_BITS]) ||
                   (dn_addr[ADDR_W-1:ALIAS_BITS] == RGN1_ALIAS[ADDR_W-1:ALIAS_BITS]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_wr   <= 1'b0;
         seen_ok   <= 1'b0;
         seen_word <= '0;
      end else begin
         if (dn_valid && dn_ready) last_wr <= dn_write;
         if (!dn_lock) seen_ok <= 1'b0;
         else if (dn_rsp_valid && !last_wr) begin
            seen_ok   <= 1'b1;
            seen_word <= dn_rdata;
         end
      end
   end

   // R7: a stalled downstream request stays put
   p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write)
                                 && $stable(dn_wdata) && $stable(dn_lock));

   // R7: response is a single-cycle pulse while busy
   p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid |=> !up_rsp_valid);

   p_busy_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid |-> !up_ready);

   // R2 and R3: alias window addresses are never forwarded
   p_no_alias_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> !in_win);

   // R6: lock is released only after a downstream response
   p_lock_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dn_lock) |-> $past(dn_rsp_valid));

   // R6: a locked write is always preceded by a locked read
   p_lock_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_write && dn_lock |-> seen_ok);

   // R5: write-back differs from the word read in at most one bit
   p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_write && dn_lock |-> $countones(dn_wdata ^ seen_word) <= 1);

endmodule

bind bitband_xlate bitband_xlate_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .WIN_BITS   (WIN_BITS),
   .RGN0_ALIAS (RGN0_ALIAS),
   .RGN1_ALIAS (RGN1_ALIAS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .up_ready     (up_ready),
   .up_rsp_valid (up_rsp_valid),
   .dn_valid     (dn_valid),
   .dn_ready     (dn_ready),
   .dn_write     (dn_write),
   .dn_lock      (dn_lock),
   .dn_addr      (dn_addr),
   .dn_wdata     (dn_wdata),
   .dn_rsp_valid (dn_rsp_valid),
   .dn_rdata     (dn_rdata)
);

// File: tb/bitband_xlate_bench.sv
module bitband_xlate_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic        up_write = 1'b0;
   logic [31:0] up_addr = '0;
   logic [31:0] up_wdata = '0;
   logic        up_rsp_valid;
   logic [31:0] up_rdata;
   logic        dn_valid;
   logic        dn_ready = 1'b0;
   logic        dn_write;
   logic        dn_lock;
   logic [31:0] dn_addr;
   logic [31:0] dn_wdata;
   logic        dn_rsp_valid = 1'b0;
   logic [31:0] dn_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitband_xlate u_bitband_xlate (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
      .up_addr(up_addr), .up_wdata(up_wdata),
      .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
      .dn_lock(dn_lock), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
      .dn_rsp_valid(dn_rsp_valid), .dn_rdata(dn_rdata)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // downstream memory model
   logic [31:0] mem [logic [31:0]];

   function automatic logic [31:0] rd_model(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   // alias mapping from the requirement arithmetic
   function automatic void map_alias(input logic [31:0] a, output bit hit,
                                     output logic [31:0] word, output int bitn);
      logic [31:0] base;
      int off, byt;
      hit = 1;
      if (a[31:25] == 7'h11)      base = 32'h2000_0000;
      else if (a[31:25] == 7'h21) base = 32'h4000_0000;
      else begin hit = 0; base = 0; end
      off  = int'(a[24:0]);
      byt  = off / 32;
      word = base + 32'(byt - (byt % 4));
      bitn = (byt % 4) * 8 + (off % 32) / 4;
   endfunction

   // transaction log
   int          n_txn;
   logic [31:0] t_addr [4];
   logic        t_write[4];
   logic        t_lock [4];
   bit          lock_watch = 0;
   bit          lock_gap = 0;
   bit          pend = 0;
   int          lat = 0;
   logic [31:0] p_addr, p_wdata;
   logic        p_write, p_lock;

   always @(negedge clk) begin
      if (lock_watch && !dn_lock) lock_gap = 1;
      dn_rsp_valid = 1'b0;
      if (pend) begin
         dn_ready = 1'b0;
         if (lat == 0) begin
            dn_rsp_valid = 1'b1;
            dn_rdata = p_write ? 32'h0 : rd_model(p_addr);
            if (p_write) begin
               mem[p_addr] = p_wdata;
               if (p_lock) lock_watch = 0;
            end
            pend = 0;
         end else lat--;
      end else if (rst_n) begin
         dn_ready = ($urandom_range(0, 3) != 0);
         if (dn_valid && dn_ready) begin
            if (n_txn < 4) begin
               t_addr[n_txn] = dn_addr; t_write[n_txn] = dn_write; t_lock[n_txn] = dn_lock;
            end
            n_txn++;
            p_addr = dn_addr; p_wdata = dn_wdata; p_write = dn_write; p_lock = dn_lock;
            pend = 1;
            lat  = $urandom_range(0, 2);
            if (dn_lock && !dn_write) lock_watch = 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_req(input logic w, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
      @(negedge clk);
      n_txn = 0; lock_gap = 0;
      up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = d;
      @(posedge clk);
      @(negedge clk);
      up_valid = 1'b0;
      check(up_ready == 1'b0, "R7", "ready while busy", 32'(up_ready), 0);
      while (!up_rsp_valid) @(negedge clk);
      rd = up_rdata;
      @(negedge clk);
      check(up_rsp_valid == 1'b0, "R7", "response pulse width", 32'(up_rsp_valid), 0);
   endtask

   task automatic do_req(input logic w, input logic [31:0] a, input logic [31:0] d);
      bit hit; logic [31:0] word, w0, expw, rd; int bitn; string rq;
      map_alias(a, hit, word, bitn);
      rq = (a[31:25] == 7'h21) ? "R3" : "R2";
      if (!hit) begin
         w0 = rd_model(a);
         run_req(w, a, d, rd);
         check(n_txn == 1, "R1", "pass txn count", 32'(n_txn), 1);
         check(t_addr[0] == a, "R1", "pass addr", t_addr[0], a);
         check(t_write[0] == w, "R1", "pass dir", 32'(t_write[0]), 32'(w));
         check(t_lock[0] == 1'b0, "R6", "pass lock", 32'(t_lock[0]), 0);
         if (w) begin
            check(rd_model(a) == d, "R1", "pass write data", rd_model(a), d);
            check(rd == 0, "R1", "pass write rsp", rd, 0);
         end else check(rd == w0, "R1", "pass read data", rd, w0);
      end else if (!w) begin
         w0 = rd_model(word);
         run_req(w, a, d, rd);
         check(n_txn == 1, "R4", "alias read txn count", 32'(n_txn), 1);
         check(t_addr[0] == word, rq, "alias read word", t_addr[0], word);
         check(t_write[0] == 1'b0, "R4", "alias read dir", 32'(t_write[0]), 0);
         check(t_lock[0] == 1'b0, "R6", "alias read lock", 32'(t_lock[0]), 0);
         check(rd == {31'b0, w0[bitn]}, "R4", "alias read bit", rd, {31'b0, w0[bitn]});
      end else begin
         w0 = rd_model(word);
         expw = w0; expw[bitn] = d[0];
         run_req(w, a, d, rd);
         check(n_txn == 2, "R5", "alias write txn count", 32'(n_txn), 2);
         check(t_addr[0] == word && t_addr[1] == word, rq, "alias write word", t_addr[1], word);
         check(t_write[0] == 1'b0 && t_write[1] == 1'b1, "R5", "rmw order",
               {30'b0, t_write[1], t_write[0]}, 32'h2);
         check(t_lock[0] && t_lock[1] && !lock_gap, "R6", "rmw lock",
               {29'b0, lock_gap, t_lock[1], t_lock[0]}, 32'h3);
         check(rd_model(word) == expw, "R5", "merged word", rd_model(word), expw);
      end
   endtask

   function automatic logic [31:0] pick_alias(input bit peri);
      logic [31:0] byt = $urandom_range(0, 63);
      logic [31:0] b   = $urandom_range(0, 7);
      return (peri ? 32'h4200_0000 : 32'h2200_0000) + byt * 32 + b * 4;
   endfunction

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10: reset state
      check(up_ready == 1'b1, "R10", "ready in reset", 32'(up_ready), 1);
      check(dn_valid == 1'b0 && dn_lock == 1'b0 && up_rsp_valid == 1'b0, "R10",
            "outputs in reset", {29'b0, dn_valid, dn_lock, up_rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(up_ready == 1'b1 && dn_valid == 1'b0, "R10", "after reset",
            {30'b0, up_ready, dn_valid}, 32'h2);

      // R8: cleared word, alias write of bit 2 of byte 0
      do_req(1'b1, 32'h2000_0000, 32'h0);
      do_req(1'b1, 32'h2200_0008, 32'hFFFF_FFF1);
      run_req(1'b0, 32'h2000_0000, 32'h0, rd);
      check(rd == 32'h4, "R8", "backing word after alias write", rd, 32'h4);

      // R9: window edges
      do_req(1'b1, 32'h23FF_FFFC, 32'h1);
      do_req(1'b0, 32'h23FF_FFFC, 32'h0);
      check(rd_model(32'h200F_FFFC) >> 31 == 32'h1, "R9", "last mem alias bit 31",
            rd_model(32'h200F_FFFC) >> 31, 1);
      do_req(1'b1, 32'h43FF_FFFC, 32'h0);
      check(rd_model(32'h400F_FFFC) >> 31 == 32'h0, "R9", "last peri alias bit 31",
            rd_model(32'h400F_FFFC) >> 31, 0);
      do_req(1'b0, 32'h21FF_FFFC, 32'h0);
      do_req(1'b1, 32'h2400_0000, 32'hCAFE_F00D);
      do_req(1'b0, 32'h41FF_FFFC, 32'h0);
      do_req(1'b1, 32'h4400_0000, 32'h1234_5678);
      do_req(1'b0, 32'h2200_0000, 32'h0);
      do_req(1'b0, 32'h4200_0000, 32'h0);

      // constrained random mix on a shared pool of words
      for (int n = 0; n < 400; n++) begin
         int kind = $urandom_range(0, 5);
         logic w = $urandom_range(0, 1) == 1;
         logic [31:0] d = $urandom;
         logic [31:0] a;
         case (kind)
            0: a = 32'h2000_0000 + 4 * $urandom_range(0, 15);
            1: a = 32'h4000_0000 + 4 * $urandom_range(0, 15);
            2: a = 32'h1000_0000 + 4 * $urandom_range(0, 255);
            3: a = pick_alias(1'b1);
            default: a = pick_alias(1'b0);
         endcase
         do_req(w, a, d);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog run did not complete");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule